// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Front End

This block is the host-facing register set of one bus-master DMA channel for a disk controller. Software programs a descriptor table base address and a command byte through a byte-addressed register port. The block turns changes of the command's run bit into start and stop controls for a separate descriptor walker, and it hands the walker a current table pointer taken from the base register. It also reports channel state through a status byte. The walker itself is outside this block and only exchanges a few control and completion signals with it.

The block also sits on the device interrupt path. The device interrupt is passed straight through to the host. Each rising edge of it is recorded in a sticky status bit that software clears by writing a one to it.

Register map (byte offsets on `regOffset`):
- command at 0;
- status at 2;
- descriptor table base at 4 to 7, little-endian.

Offsets 1 and 3 read as zero and ignore writes.

Top module: `bm_dma_regs`

## Requirements
- R1: A write to offset 0 stores only bits 0 (run) and 3 (direction) of `regWrData[7:0]`, so the stored value is the write data AND 0x09. A read of offset 0 returns the stored byte, and `walkDir` equals stored bit 3.
- R2: A command write whose bit 0 equals the stored run bit updates the stored command only. It produces no `walkLaunch` or `walkHalt` pulse and does not reload `walkTablePtr`.
- R3: A command write that changes the run bit from 0 to 1 copies the base register into `walkTablePtr` and sets status bit 0 (active). If active was clear and `xferPending` is high, the same clock edge also raises `walkLaunch` for one cycle.
- R4: A command write that changes the run bit from 1 to 0 clears active only at a clock edge where `walkBusy` is low. It waits as long as `walkBusy` stays high. When active falls this way, `walkHalt` pulses for one cycle.
- R5: Base register writes at offsets 4 to 7 update only the bytes selected by offset and width. Width is set by `regSize`: 0 is 1 byte, 1 is 2 bytes, 2 or 3 is 4 bytes. The data is shifted left by 8 times (offset−4). Bits 1:0 of the base are always stored as zero.
- R6: A read at offset 4+k returns the base shifted right by 8·k bits, masked to the access width.
- R7: `hostIrq` follows `devIrq` combinationally. A rising `devIrq` sets status bit 2 (interrupt). A falling `devIrq` leaves bit 2 unchanged.
- R8: Status bit 1 (error) is set by a `walkErr` pulse. Bits 1 and 2 are cleared by writing 1 to them at offset 2. Bit 0 cannot be changed by a status write.
- R9: A `walkDone` pulse clears active and clears `unitValid`.
- R10: Reset clears the command, status, base, `walkTablePtr`, the drive selection and any pending stop.
- R11: A `unitSet` pulse loads `unitNum` into `unitCur` and sets `unitValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regOffset | input | 3 | Byte offset of the access |
| regSize | input | 2 | Access width code (0=1, 1=2, else 4 bytes) |
| regWrData | input | 32 | Write data, right-aligned |
| regRdData | output | 32 | Read data for the current offset and width |
| devIrq | input | 1 | Device interrupt level |
| hostIrq | output | 1 | Interrupt level to the host |
| xferPending | input | 1 | A transfer request is waiting for the channel |
| walkBusy | input | 1 | Walker has a memory transfer in flight |
| walkDone | input | 1 | Walker finished or was cancelled (pulse) |
| walkErr | input | 1 | Walker error (pulse) |
| unitSet | input | 1 | Load the selected drive (pulse) |
| unitNum | input | 1 | Drive number to select |
| walkLaunch | output | 1 | One-cycle start pulse to the walker |
| walkHalt | output | 1 | One-cycle pulse when a stop takes effect |
| walkDir | output | 1 | Transfer direction from command bit 3 |
| walkTablePtr | output | 32 | Current descriptor table pointer |
| unitValid | output | 1 | A drive is selected |
| unitCur | output | 1 | Selected drive number |

## Verification
The assertions assume the following about the inputs:
- `walkDone` is not pulsed in the same cycle as a command write that sets the run bit;
- `walkBusy` only drops when the walker really ends a transfer;
- register inputs are stable around the clock edge.

The directed bench drives every input at the falling clock edge and keeps `walkDone`, `walkErr` and `unitSet` to single-cycle pulses issued apart from command writes. It holds `walkBusy` high across a stop request for several cycles before releasing it.

// File: rtl/bm_regs_pkg.sv
package bm_regs_pkg;
  localparam logic [7:0] CMD_KEEP_MASK = 8'h09;
  localparam int         RUN_BIT       = 0;
  localparam int         DIR_BIT       = 3;
  localparam int         ST_ACTIVE     = 0;
  localparam int         ST_ERROR      = 1;
  localparam int         ST_IRQ        = 2;
  localparam logic [2:0] OFF_CMD       = 3'd0;
  localparam logic [2:0] OFF_STATUS    = 3'd2;

  typedef struct packed {
    logic loadPtr;
    logic baseWr;
  } strobe_t;
endpackage

// File: rtl/bm_ctrl.sv
module bm_ctrl
  import bm_regs_pkg::*;
#(
  parameter int UNIT_W = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regOffset,
  input  logic [7:0]        regWrByte,
  input  logic              devIrq,
  input  logic              xferPending,
  input  logic              walkBusy,
  input  logic              walkDone,
  input  logic              walkErr,
  input  logic              unitSet,
  input  logic [UNIT_W-1:0] unitNum,
  output strobe_t           strb,
  output logic [7:0]        cmdQ,
  output logic [7:0]        statusQ,
  output logic              walkLaunch,
  output logic              walkHalt,
  output logic              unitValid,
  output logic [UNIT_W-1:0] unitCur
);
  logic activeQ, errQ, irqQ, stopPend, devIrqQ;
  logic cmdWr, stsWr, goUp, goDown, devRise;

  assign cmdWr   = regWrEn && (regOffset == OFF_CMD);
  assign stsWr   = regWrEn && (regOffset == OFF_STATUS);
  assign goUp    = cmdWr && regWrByte[RUN_BIT] && !cmdQ[RUN_BIT];
  assign goDown  = cmdWr && !regWrByte[RUN_BIT] && cmdQ[RUN_BIT];
  assign devRise = devIrq && !devIrqQ;

  always_comb begin
    strb.loadPtr = goUp;
    strb.baseWr  = regWrEn && regOffset[2];
    statusQ      = 8'h00;
    statusQ[ST_ACTIVE] = activeQ;
    statusQ[ST_ERROR]  = errQ;
    statusQ[ST_IRQ]    = irqQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ       <= 8'h00;
      activeQ    <= 1'b0;
      errQ       <= 1'b0;
      irqQ       <= 1'b0;
      stopPend   <= 1'b0;
      devIrqQ    <= 1'b0;
      walkLaunch <= 1'b0;
      walkHalt   <= 1'b0;
      unitValid  <= 1'b0;
      unitCur    <= '0;
    end else begin
      walkLaunch <= 1'b0;
      walkHalt   <= 1'b0;
      devIrqQ    <= devIrq;
      if (cmdWr) cmdQ <= regWrByte & CMD_KEEP_MASK;

      if (goUp) begin
        stopPend <= 1'b0;
        if (!activeQ) begin
          activeQ    <= 1'b1;
          walkLaunch <= xferPending;
        end
      end else if (walkDone) begin
        activeQ  <= 1'b0;
        stopPend <= 1'b0;
      end else if (goDown || stopPend) begin
        if (!walkBusy) begin
          activeQ  <= 1'b0;
          stopPend <= 1'b0;
          walkHalt <= activeQ;
        end else begin
          stopPend <= 1'b1;
        end
      end

      if (walkErr)                          errQ <= 1'b1;
      else if (stsWr && regWrByte[ST_ERROR]) errQ <= 1'b0;
      if (devRise)                          irqQ <= 1'b1;
      else if (stsWr && regWrByte[ST_IRQ])   irqQ <= 1'b0;

      if (walkDone) begin
        unitValid <= 1'b0;
      end else if (unitSet) begin
        unitValid <= 1'b1;
        unitCur   <= unitNum;
      end
    end
  end

  // R4
  stop_waits_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(activeQ) |-> ($past(walkDone) || !$past(walkBusy)));
  // R3
  launch_needs_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    walkLaunch |-> activeQ);
  // R8
  status_write_keeps_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(stsWr && !walkDone && !stopPend) |-> (activeQ == $past(activeQ)));
  // R7
  irq_rise_latched_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(devIrq) |=> irqQ);
  // R2
  no_launch_halt_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(walkLaunch && walkHalt));
endmodule

// File: rtl/bm_datapath.sv
module bm_datapath
  import bm_regs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [2:0]        regOffset,
  input  logic [1:0]        regSize,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [7:0]        cmdQ,
  input  logic [7:0]        statusQ,
  output logic [DATA_W-1:0] regRdData,
  output logic [DATA_W-1:0] walkTablePtr
);
  localparam int LANES = DATA_W / 8;
  localparam int LW    = $clog2(LANES) + 1;

  logic [DATA_W-1:0] baseQ, wrShifted, rdShifted, widthMask;
  logic [LW-1:0]     relLane, nBytes;

  assign relLane   = LW'(regOffset[1:0]);
  assign nBytes    = (regSize == 2'd0) ? LW'(1) : (regSize == 2'd1) ? LW'(2) : LW'(LANES);
  assign wrShifted = regWrData << {regOffset[1:0], 3'b000};
  assign rdShifted = baseQ >> {regOffset[1:0], 3'b000};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic laneHit;
    logic [7:0] laneData;
    assign laneHit  = strb.baseWr && (LW'(i) >= relLane) && (LW'(i) < relLane + nBytes);
    if (i == 0) begin : g_low
      assign laneData = wrShifted[7:0] & 8'hFC;
    end else begin : g_up
      assign laneData = wrShifted[8*i +: 8];
    end
    always_ff @(posedge clk) begin
      if (!rstN)        baseQ[8*i +: 8] <= 8'h00;
      else if (laneHit) baseQ[8*i +: 8] <= laneData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             walkTablePtr <= '0;
    else if (strb.loadPtr) walkTablePtr <= baseQ;
  end

  always_comb begin
    case (regSize)
      2'd0:    widthMask = DATA_W'(8'hFF);
      2'd1:    widthMask = DATA_W'(16'hFFFF);
      default: widthMask = '1;
    endcase
    if (regOffset[2])                  regRdData = rdShifted & widthMask;
    else if (regOffset == OFF_CMD)     regRdData = DATA_W'(cmdQ);
    else if (regOffset == OFF_STATUS)  regRdData = DATA_W'(statusQ);
    else                               regRdData = '0;
  end

  // R5
  base_low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    walkTablePtr[1:0] == 2'b00);
  // R3
  ptr_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.loadPtr) |-> (walkTablePtr == $past(baseQ)));
endmodule

// File: rtl/bm_dma_regs.sv
module bm_dma_regs
  import bm_regs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int UNIT_W = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regOffset,
  input  logic [1:0]        regSize,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              devIrq,
  output logic              hostIrq,
  input  logic              xferPending,
  input  logic              walkBusy,
  input  logic              walkDone,
  input  logic              walkErr,
  input  logic              unitSet,
  input  logic [UNIT_W-1:0] unitNum,
  output logic              walkLaunch,
  output logic              walkHalt,
  output logic              walkDir,
  output logic [DATA_W-1:0] walkTablePtr,
  output logic              unitValid,
  output logic [UNIT_W-1:0] unitCur
);
  strobe_t    strb;
  logic [7:0] cmdQ, statusQ;

  assign hostIrq = devIrq;
  assign walkDir = cmdQ[DIR_BIT];

  bm_ctrl #(.UNIT_W(UNIT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regOffset(regOffset),
    .regWrByte(regWrData[7:0]), .devIrq(devIrq), .xferPending(xferPending),
    .walkBusy(walkBusy), .walkDone(walkDone), .walkErr(walkErr),
    .unitSet(unitSet), .unitNum(unitNum), .strb(strb), .cmdQ(cmdQ),
    .statusQ(statusQ), .walkLaunch(walkLaunch), .walkHalt(walkHalt),
    .unitValid(unitValid), .unitCur(unitCur)
  );

  bm_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regOffset(regOffset),
    .regSize(regSize), .regWrData(regWrData), .cmdQ(cmdQ), .statusQ(statusQ),
    .regRdData(regRdData), .walkTablePtr(walkTablePtr)
  );
endmodule

// File: tb/bm_dma_regs_tb.sv
`timescale 1ns/1ps
module bm_dma_regs_tb;
  logic clk = 1'b0, rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [2:0] regOffset = 3'd0;
  logic [1:0] regSize = 2'd0;
  logic [31:0] regWrData = 32'd0, regRdData, walkTablePtr;
  logic devIrq = 1'b0, hostIrq, xferPending = 1'b0, walkBusy = 1'b0;
  logic walkDone = 1'b0, walkErr = 1'b0, unitSet = 1'b0;
  logic [0:0] unitNum = 1'b0, unitCur;
  logic walkLaunch, walkHalt, walkDir, unitValid;
  int testCnt = 0, failCnt = 0;

  always #10 clk = ~clk;

  bm_dma_regs u_dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] off, logic [1:0] sz, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regOffset = off; regSize = sz; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [2:0] off, logic [1:0] sz, output logic [31:0] d);
    regOffset = off; regSize = sz;
    #1 d = regRdData;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(0, 0, d); chk("R10 cmd after reset", d, 0);
    rd(2, 0, d); chk("R10 status after reset", d, 0);
    rd(4, 2, d); chk("R10 base after reset", d, 0);
    chk("R10 ptr after reset", walkTablePtr, 0);
    chk("R10 unitValid after reset", unitValid, 0);
  endtask

  task automatic t_base();
    logic [31:0] d;
    wr(4, 2, 32'h12345677); rd(4, 2, d); chk("R5 word write low bits zero", d, 32'h12345674);
    wr(5, 0, 32'h000000AB); rd(4, 2, d); chk("R5 byte lane 1 write", d, 32'h1234AB74);
    wr(4, 0, 32'h000000FF); rd(4, 2, d); chk("R5 byte lane 0 write", d, 32'h1234ABFC);
    rd(6, 1, d); chk("R6 half read at 6", d, 32'h1234);
    rd(5, 0, d); chk("R6 byte read at 5", d, 32'hAB);
    rd(5, 2, d); chk("R6 word read at 5", d, 32'h001234AB);
  endtask

  task automatic t_start();
    logic [31:0] d;
    xferPending = 1'b1;
    wr(0, 0, 32'hFF);
    chk("R3 launch pulse", walkLaunch, 1);
    chk("R3 ptr reload", walkTablePtr, 32'h1234ABFC);
    rd(0, 0, d); chk("R1 cmd masked", d, 32'h09);
    chk("R1 dir bit", walkDir, 1);
    rd(2, 0, d); chk("R3 active set", d, 32'h01);
  endtask

  task automatic t_same();
    wr(4, 2, 32'h00000100);
    chk("R2 launch clears", walkLaunch, 0);
    wr(0, 0, 32'h01);
    chk("R2 no launch", walkLaunch, 0);
    chk("R2 no halt", walkHalt, 0);
    chk("R2 no reload", walkTablePtr, 32'h1234ABFC);
    chk("R1 dir follows update", walkDir, 0);
  endtask

  task automatic t_stop_busy();
    logic [31:0] d;
    walkBusy = 1'b1;
    wr(0, 0, 32'h00);
    rd(2, 0, d); chk("R4 active held while busy", d, 32'h01);
    chk("R4 no halt while busy", walkHalt, 0);
    repeat (3) @(negedge clk);
    rd(2, 0, d); chk("R4 still active", d, 32'h01);
    walkBusy = 1'b0;
    @(negedge clk);
    chk("R4 halt after busy drops", walkHalt, 1);
    rd(2, 0, d); chk("R4 active cleared", d, 32'h00);
  endtask

  task automatic t_restart_ro();
    logic [31:0] d;
    xferPending = 1'b0;
    wr(0, 0, 32'h01);
    chk("R3 no launch without pending", walkLaunch, 0);
    chk("R3 reload new base", walkTablePtr, 32'h00000100);
    wr(2, 0, 32'h07);
    rd(2, 0, d); chk("R8 active read-only", d, 32'h01);
    wr(0, 0, 32'h00);
    chk("R4 immediate halt", walkHalt, 1);
    rd(2, 0, d); chk("R4 idle stop clears active", d, 32'h00);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    @(negedge clk); devIrq = 1'b1;
    #1 chk("R7 host irq high", hostIrq, 1);
    @(negedge clk);
    rd(2, 0, d); chk("R7 irq bit set", d, 32'h04);
    devIrq = 1'b0;
    #1 chk("R7 host irq low", hostIrq, 0);
    @(negedge clk);
    rd(2, 0, d); chk("R7 fall keeps bit", d, 32'h04);
    wr(2, 0, 32'h04);
    rd(2, 0, d); chk("R8 irq W1C", d, 32'h00);
    pulse(walkErr);
    rd(2, 0, d); chk("R8 error set", d, 32'h02);
    wr(2, 0, 32'h04);
    rd(2, 0, d); chk("R8 other bit write keeps error", d, 32'h02);
    wr(2, 0, 32'h02);
    rd(2, 0, d); chk("R8 error W1C", d, 32'h00);
  endtask

  task automatic t_unit();
    logic [31:0] d;
    unitNum = 1'b1;
    pulse(unitSet);
    chk("R11 unit valid", unitValid, 1);
    chk("R11 unit number", unitCur, 1);
    wr(0, 0, 32'h01);
    pulse(walkDone);
    rd(2, 0, d); chk("R9 done clears active", d, 32'h00);
    chk("R9 done clears unit", unitValid, 0);
  endtask

  task automatic t_reset_mid();
    logic [31:0] d;
    wr(0, 0, 32'h00);
    wr(4, 2, 32'hDEADBEEF);
    wr(0, 0, 32'h09);
    pulse(unitSet);
    @(negedge clk); devIrq = 1'b1;
    @(negedge clk); rstN = 1'b0; devIrq = 1'b0;
    @(negedge clk); rstN = 1'b1;
    rd(0, 0, d); chk("R10 cmd cleared", d, 0);
    rd(2, 0, d); chk("R10 status cleared", d, 0);
    rd(4, 2, d); chk("R10 base cleared", d, 0);
    chk("R10 ptr cleared", walkTablePtr, 0);
    chk("R10 unit cleared", unitValid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_base();
    t_start();
    t_same();
    t_stop_busy();
    t_restart_ro();
    t_irq();
    t_unit();
    t_reset_mid();
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    testCnt++; failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule